// File: doc/BRIEF.md
# Multi-channel DMA control register bank

This block is the software-facing control and status register bank of a DMA engine with up to 64 channels. It stores the global control bits and four per-channel bitmaps: request enable, error-interrupt enable, interrupt flag and error flag. It also keeps a per-channel done bitmap, issues per-channel start pulses and holds a captured error status word. Each bitmap occupies two 32-bit words: the high word covers channels 63..32 and the low word covers channels 31..0. The data mover, channel arbitration and bus mastering sit outside the block.

Software changes one channel's bit by writing that channel's index into a byte-wide command lane, so it never has to read, modify and write a shared bitmap. The engine reports per-channel done pulses and single error events that carry a channel number and a set of fault-class bits. The first error that arrives while the status word is empty is latched together with its channel number. The block drives one combined interrupt line.

Register map (word index = byte offset / 4): 0 control, 1 error status, 2/3 request enable high/low, 4/5 error-interrupt enable high/low, 6 and 7 byte command words, 8/9 interrupt flags high/low, 10/11 error flags high/low. Any other word index reads as zero.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every register reads as zero, and irq, req_enable, chan_done and start_pulse are all low.
- R2: A write to word 0 stores bit 31 (clock gating enable), bit 3 (round-robin group arbitration) and bit 2 (round-robin channel arbitration). These bits drive ctrl_clk_gate, ctrl_rr_group and ctrl_rr_chan. Every other bit of word 0 reads as zero.
- R3: In word 6, byte lane 0 (wdata[7:0], strb[0]) sets the indexed channel's request-enable bit and lane 1 (wdata[15:8], strb[1]) clears it. Channel i reads at bit i of word 3 for i < 32 and at bit i-32 of word 2 otherwise. When set and clear name the same channel in one write, clear wins.
- R4: In word 6, lane 2 sets and lane 3 clears the indexed channel's error-interrupt-enable bit, which reads in words 4 (high) and 5 (low). Clear wins over set.
- R5: A write to words 2 through 5 loads that whole half bitmap from wdata, regardless of bus_strb.
- R6: A done_evt bit sets that channel's interrupt flag (words 8/9) and its chan_done bit. In word 7, lane 3 clears one chan_done bit.
- R7: Writing ones to words 8 through 11 clears the matching interrupt or error flags. In word 7, lane 0 clears one interrupt flag and lane 1 clears one error flag. An event arriving in the same cycle as a clear keeps its flag set.
- R8: An error event sets the channel's error flag (words 10/11). It asserts irq only while that channel's error-interrupt enable is set.
- R9: While status word bit 31 is clear, an error event is latched into the status word as follows: bit 31 = 1, bits 15 and 14 = kind[9] and kind[8], bits 13:8 = channel, bits 7:0 = kind[7:0]. While bit 31 is set, later events leave the status word unchanged.
- R10: A clear-error command (word 7 lane 1, index in range) clears the whole status word. An error event in the same cycle is latched instead.
- R11: In word 7, lane 2 produces a one-cycle pulse on start_pulse for the indexed channel, in the cycle after the write.
- R12: A command byte whose value is NCH or above has no effect on any bitmap or output.
- R13: irq is high exactly when any interrupt flag is set or any error flag whose error-interrupt enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_word | input | 4 | Word index for both read and write |
| bus_strb | input | 4 | Byte lane enables; used only by the command words |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_word (combinational) |
| done_evt | input | NCH | Per-channel done pulses from the engine |
| err_evt | input | 1 | Error event strobe from the engine |
| err_evt_chan | input | 6 | Channel of the error event |
| err_evt_kind | input | 10 | Fault-class bits of the error event |
| irq | output | 1 | Combined interrupt |
| ctrl_clk_gate | output | 1 | Clock gating enable |
| ctrl_rr_group | output | 1 | Round-robin group arbitration select |
| ctrl_rr_chan | output | 1 | Round-robin channel arbitration select |
| req_enable | output | NCH | Per-channel request enables |
| chan_done | output | NCH | Per-channel done bits |
| start_pulse | output | NCH | Per-channel one-cycle start pulses |

## Verification
Two pairs of functions can land in the same clock edge and need a defined outcome. The first pair is an engine event and a software clear of the same flag. The bench drives a done pulse together with a single-channel clear or a write-ones clear of the same word, and drives an error event together with a clear-error command. It expects the event to survive and the new error to be latched. The second pair is a set and a clear of one channel in the same command word. The bench writes both lanes at once and expects the bit to end up cleared.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;
   localparam int MAX_CH   = 64;
   localparam int IDX_W    = 6;
   localparam int KIND_W   = 10;
   localparam int N_CMD    = 8;

   // word indices
   localparam logic [3:0] W_CTRL   = 4'd0;
   localparam logic [3:0] W_ESTAT  = 4'd1;
   localparam logic [3:0] W_REQ_HI = 4'd2;
   localparam logic [3:0] W_REQ_LO = 4'd3;
   localparam logic [3:0] W_EEI_HI = 4'd4;
   localparam logic [3:0] W_EEI_LO = 4'd5;
   localparam logic [3:0] W_CMD_A  = 4'd6;
   localparam logic [3:0] W_CMD_B  = 4'd7;
   localparam logic [3:0] W_INT_HI = 4'd8;
   localparam logic [3:0] W_INT_LO = 4'd9;
   localparam logic [3:0] W_ERR_HI = 4'd10;
   localparam logic [3:0] W_ERR_LO = 4'd11;

   // command lanes: word 6 lanes 0..3, word 7 lanes 0..3
   localparam int C_SET_REQ   = 0;
   localparam int C_CLR_REQ   = 1;
   localparam int C_SET_EEI   = 2;
   localparam int C_CLR_EEI   = 3;
   localparam int C_CLR_INT   = 4;
   localparam int C_CLR_ERR   = 5;
   localparam int C_SET_START = 6;
   localparam int C_CLR_DONE  = 7;

   localparam int CTRL_GATE_B = 31;
   localparam int CTRL_RRG_B  = 3;
   localparam int CTRL_RRC_B  = 2;
endpackage

// File: rtl/dcr_cmd_decode.sv
module dcr_cmd_decode
   import dma_chan_regs_pkg::*;
#(
   parameter int NCH = 64
) (
   input  logic                       bus_we,
   input  logic [3:0]                 bus_word,
   input  logic [3:0]                 bus_strb,
   input  logic [31:0]                bus_wdata,
   output logic [N_CMD-1:0][NCH-1:0]  cmd_hot,
   output logic [N_CMD-1:0]           cmd_any
);
   generate
      for (genvar l = 0; l < N_CMD; l++) begin : g_lane
         localparam logic [3:0] LWORD = W_CMD_A + 4'(l / 4);
         localparam int         LBYTE = l % 4;
         logic [7:0] idx;
         logic       hit;
         assign idx        = bus_wdata[8*LBYTE +: 8];
         assign hit        = bus_we && (bus_word == LWORD) && bus_strb[LBYTE]
                             && (int'(idx) < NCH);
         assign cmd_any[l] = hit;
         for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign cmd_hot[l][c] = hit && (idx == 8'(c));
         end
      end
   endgenerate
endmodule

// File: rtl/dcr_flag_array.sv
module dcr_flag_array #(
   parameter int N        = 64,
   parameter bit CLR_WINS = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] ld_mask,
   input  logic [N-1:0] ld_val,
   input  logic [N-1:0] set_vec,
   input  logic [N-1:0] clr_vec,
   output logic [N-1:0] q
);
   logic [N-1:0] base, nxt;

   if (N < 1) begin : g_bad_n
      initial $fatal(1, "dcr_flag_array: N must be positive");
   end

   assign base = (q & ~ld_mask) | (ld_val & ld_mask);

   generate
      if (CLR_WINS) begin : g_clr_wins
         assign nxt = (base | set_vec) & ~clr_vec;
      end else begin : g_set_wins
         assign nxt = (base & ~clr_vec) | set_vec;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= nxt;
   end
endmodule

// File: rtl/dcr_err_capture.sv
module dcr_err_capture
   import dma_chan_regs_pkg::*;
#(
   parameter int NCH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              evt,
   input  logic [IDX_W-1:0]  chan,
   input  logic [KIND_W-1:0] kind,
   output logic [31:0]       status
);
   logic        held;
   logic        take;
   logic [31:0] packed_word;

   assign held        = status[31] & ~clr;
   assign take        = evt && !held && (int'(chan) < NCH);
   assign packed_word = {1'b1, 15'b0, kind[9], kind[8], chan, kind[7:0]};

   always_ff @(posedge clk) begin
      if (!rst_n)   status <= '0;
      else if (take) status <= packed_word;
      else if (clr)  status <= '0;
   end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_chan_regs_pkg::*;
#(
   parameter int NCH = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_we,
   input  logic [3:0]        bus_word,
   input  logic [3:0]        bus_strb,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NCH-1:0]    done_evt,
   input  logic              err_evt,
   input  logic [IDX_W-1:0]  err_evt_chan,
   input  logic [KIND_W-1:0] err_evt_kind,
   output logic              irq,
   output logic              ctrl_clk_gate,
   output logic              ctrl_rr_group,
   output logic              ctrl_rr_chan,
   output logic [NCH-1:0]    req_enable,
   output logic [NCH-1:0]    chan_done,
   output logic [NCH-1:0]    start_pulse
);
   if (NCH != 32 && NCH != MAX_CH) begin : g_bad_nch
      initial $fatal(1, "dma_chan_regs: NCH must be 32 or 64");
   end

   logic [N_CMD-1:0][NCH-1:0] cmd_hot;
   logic [N_CMD-1:0]          cmd_any;
   logic [63:0] req_ld64, eei_ld64, int_w1c64, err_w1c64, wdup64;
   logic [NCH-1:0] eei_q, int_q, err_q, err_hot, no_load;
   logic [31:0] estat_q;
   logic [63:0] req64, eei64, int64, err64;

   dcr_cmd_decode #(.NCH(NCH)) u_dec (
      .bus_we(bus_we), .bus_word(bus_word), .bus_strb(bus_strb),
      .bus_wdata(bus_wdata), .cmd_hot(cmd_hot), .cmd_any(cmd_any));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_clk_gate <= 1'b0;
         ctrl_rr_group <= 1'b0;
         ctrl_rr_chan  <= 1'b0;
         start_pulse   <= '0;
      end else begin
         if (bus_we && bus_word == W_CTRL) begin
            ctrl_clk_gate <= bus_wdata[CTRL_GATE_B];
            ctrl_rr_group <= bus_wdata[CTRL_RRG_B];
            ctrl_rr_chan  <= bus_wdata[CTRL_RRC_B];
         end
         start_pulse <= cmd_hot[C_SET_START];
      end
   end

   function automatic logic [63:0] half_sel(input logic hi, input logic lo);
      return {{32{hi}}, {32{lo}}};
   endfunction

   assign wdup64    = {bus_wdata, bus_wdata};
   assign req_ld64  = half_sel(bus_we && bus_word == W_REQ_HI, bus_we && bus_word == W_REQ_LO);
   assign eei_ld64  = half_sel(bus_we && bus_word == W_EEI_HI, bus_we && bus_word == W_EEI_LO);
   assign int_w1c64 = wdup64 & half_sel(bus_we && bus_word == W_INT_HI, bus_we && bus_word == W_INT_LO);
   assign err_w1c64 = wdup64 & half_sel(bus_we && bus_word == W_ERR_HI, bus_we && bus_word == W_ERR_LO);
   assign err_hot   = (err_evt && (int'(err_evt_chan) < NCH)) ? (NCH'(1) << err_evt_chan) : '0;
   assign no_load   = '0;

   dcr_flag_array #(.N(NCH), .CLR_WINS(1'b1)) u_req (
      .clk(clk), .rst_n(rst_n), .ld_mask(NCH'(req_ld64)), .ld_val(NCH'(wdup64)),
      .set_vec(cmd_hot[C_SET_REQ]), .clr_vec(cmd_hot[C_CLR_REQ]), .q(req_enable));

   dcr_flag_array #(.N(NCH), .CLR_WINS(1'b1)) u_eei (
      .clk(clk), .rst_n(rst_n), .ld_mask(NCH'(eei_ld64)), .ld_val(NCH'(wdup64)),
      .set_vec(cmd_hot[C_SET_EEI]), .clr_vec(cmd_hot[C_CLR_EEI]), .q(eei_q));

   dcr_flag_array #(.N(NCH), .CLR_WINS(1'b0)) u_int (
      .clk(clk), .rst_n(rst_n), .ld_mask(no_load), .ld_val(no_load),
      .set_vec(done_evt), .clr_vec(cmd_hot[C_CLR_INT] | NCH'(int_w1c64)), .q(int_q));

   dcr_flag_array #(.N(NCH), .CLR_WINS(1'b0)) u_err (
      .clk(clk), .rst_n(rst_n), .ld_mask(no_load), .ld_val(no_load),
      .set_vec(err_hot), .clr_vec(cmd_hot[C_CLR_ERR] | NCH'(err_w1c64)), .q(err_q));

   dcr_flag_array #(.N(NCH), .CLR_WINS(1'b0)) u_done (
      .clk(clk), .rst_n(rst_n), .ld_mask(no_load), .ld_val(no_load),
      .set_vec(done_evt), .clr_vec(cmd_hot[C_CLR_DONE]), .q(chan_done));

   dcr_err_capture #(.NCH(NCH)) u_cap (
      .clk(clk), .rst_n(rst_n), .clr(cmd_any[C_CLR_ERR]), .evt(err_evt),
      .chan(err_evt_chan), .kind(err_evt_kind), .status(estat_q));

   assign irq = (|int_q) | (|(err_q & eei_q));

   assign req64 = 64'(req_enable);
   assign eei64 = 64'(eei_q);
   assign int64 = 64'(int_q);
   assign err64 = 64'(err_q);

   always_comb begin
      case (bus_word)
         W_CTRL:   bus_rdata = {ctrl_clk_gate, 27'b0, ctrl_rr_group, ctrl_rr_chan, 2'b0};
         W_ESTAT:  bus_rdata = estat_q;
         W_REQ_HI: bus_rdata = req64[63:32];
         W_REQ_LO: bus_rdata = req64[31:0];
         W_EEI_HI: bus_rdata = eei64[63:32];
         W_EEI_LO: bus_rdata = eei64[31:0];
         W_INT_HI: bus_rdata = int64[63:32];
         W_INT_LO: bus_rdata = int64[31:0];
         W_ERR_HI: bus_rdata = err64[63:32];
         W_ERR_LO: bus_rdata = err64[31:0];
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dcr_checker.sv
module dcr_checker
   import dma_chan_regs_pkg::*;
#(
   parameter int NCH = 64
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_we,
   input logic [3:0]       bus_word,
   input logic             strb1,
   input logic             strb2,
   input logic [7:0]       lane1_byte,
   input logic [NCH-1:0]   done_evt,
   input logic             err_evt,
   input logic [IDX_W-1:0] err_evt_chan,
   input logic             irq,
   input logic [NCH-1:0]   chan_done,
   input logic [NCH-1:0]   req_enable,
   input logic [NCH-1:0]   start_pulse,
   input logic [31:0]      estat
);
   logic clr_err_cmd, clr_req_cmd;
   assign clr_err_cmd = bus_we && bus_word == W_CMD_B && strb1 && (int'(lane1_byte) < NCH);
   assign clr_req_cmd = bus_we && bus_word == W_CMD_A && strb1 && (int'(lane1_byte) < NCH);

   // R11
   start_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(start_pulse));

   // R11
   start_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_pulse != '0) |-> $past(bus_we && bus_word == W_CMD_B && strb2));

   // R6
   done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_evt != '0) |=> (irq && ((chan_done & $past(done_evt)) == $past(done_evt))));

   // R3
   req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr_req_cmd |=> !req_enable[$past(lane1_byte[IDX_W-1:0])]);

   // R9
   err_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_evt && (!estat[31] || clr_err_cmd) && (int'(err_evt_chan) < NCH))
      |=> (estat[31] && estat[13:8] == $past(err_evt_chan)));

   // R10
   estat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (estat[31] && !clr_err_cmd) |=> $stable(estat));
endmodule

bind dma_chan_regs dcr_checker #(.NCH(NCH)) u_dcr_chk (
   .*,
   .strb1(bus_strb[1]),
   .strb2(bus_strb[2]),
   .lane1_byte(bus_wdata[15:8]),
   .estat(estat_q)
);

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;
   localparam int NCH = 64;
   localparam logic [3:0] CTRL = 0, ESTAT = 1, REQ_HI = 2, REQ_LO = 3, EEI_HI = 4,
      EEI_LO = 5, CMD_A = 6, CMD_B = 7, INT_HI = 8, INT_LO = 9, ERR_HI = 10, ERR_LO = 11;

   logic clk = 0, rst_n = 0, bus_we = 0, err_evt = 0;
   logic [3:0] bus_word = 0, bus_strb = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic [NCH-1:0] done_evt = '0, req_enable, chan_done, start_pulse;
   logic [5:0] err_evt_chan = 0;
   logic [9:0] err_evt_kind = 0;
   logic irq, ctrl_clk_gate, ctrl_rr_group, ctrl_rr_chan;
   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [63:0] req_m, eei_m, v64;
   logic [31:0] d;

   always #10 clk = ~clk;

   dma_chan_regs #(.NCH(NCH)) u_dma_chan_regs (.*);

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_full(input logic [3:0] w, input logic [3:0] s, input logic [31:0] v,
                          input logic [63:0] dv, input logic ev, input logic [5:0] ch,
                          input logic [9:0] kd);
      @(negedge clk);
      bus_we = 1; bus_word = w; bus_strb = s; bus_wdata = v;
      done_evt = dv; err_evt = ev; err_evt_chan = ch; err_evt_kind = kd;
      @(negedge clk);
      bus_we = 0; bus_strb = 0; done_evt = '0; err_evt = 0;
   endtask

   task automatic wr(input logic [3:0] w, input logic [3:0] s, input logic [31:0] v);
      wr_full(w, s, v, '0, 1'b0, 6'd0, 10'd0);
   endtask

   task automatic pulse_done(input logic [63:0] dv);
      wr_full(4'd15, 4'h0, 32'h0, dv, 1'b0, 6'd0, 10'd0);
   endtask

   task automatic pulse_err(input logic [5:0] ch, input logic [9:0] kd);
      wr_full(4'd15, 4'h0, 32'h0, '0, 1'b1, ch, kd);
   endtask

   task automatic rd(input logic [3:0] w, output logic [31:0] v);
      bus_word = w; #1; v = bus_rdata;
   endtask

   task automatic rd64(input logic [3:0] hi, output logic [63:0] v);
      logic [31:0] h, l;
      rd(hi, h); rd(hi + 4'd1, l); v = {h, l};
   endtask

   task automatic report;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         report;
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      for (int w = 0; w < 12; w++) begin
         rd(4'(w), d); check("R1 reset word", d, 0);
      end
      check("R1 reset outputs", {irq, req_enable, chan_done, start_pulse}, 0);

      // R2 control word
      wr(CTRL, 4'hF, 32'hFFFF_FFFF);
      rd(CTRL, d); check("R2 ctrl read", d, 32'h8000_000C);
      check("R2 ctrl outs", {ctrl_clk_gate, ctrl_rr_group, ctrl_rr_chan}, 3'b111);
      wr(CTRL, 4'hF, 32'h0000_0008);
      check("R2 ctrl outs partial", {ctrl_clk_gate, ctrl_rr_group, ctrl_rr_chan}, 3'b010);

      // R3 set sweep then clear evens
      req_m = 0;
      for (int c = 0; c < NCH; c++) begin
         wr(CMD_A, 4'b0001, 32'(c));
         req_m |= 64'd1 << c;
         rd64(REQ_HI, v64); check("R3 set sweep", v64, req_m);
      end
      for (int c = 0; c < NCH; c += 2) begin
         wr(CMD_A, 4'b0010, 32'(c) << 8);
         req_m &= ~(64'd1 << c);
      end
      rd64(REQ_HI, v64); check("R3 clear evens", v64, req_m);
      wr(CMD_A, 4'b0011, 32'h0000_0505);
      req_m &= ~(64'd1 << 5);
      check("R3 set+clear same channel", 64'(req_enable), req_m);
      wr(CMD_A, 4'b0011, 32'h0000_0706);
      req_m = (req_m | (64'd1 << 6)) & ~(64'd1 << 7);
      check("R3 set and clear distinct", 64'(req_enable), req_m);

      // R5 word load, strobes ignored
      wr(REQ_LO, 4'hF, 32'hA5A5_5A5A);
      wr(REQ_HI, 4'h0, 32'h0F0F_1234);
      req_m = 64'h0F0F_1234_A5A5_5A5A;
      rd64(REQ_HI, v64); check("R5 req load", v64, req_m);

      // R4 error-interrupt enable
      wr(EEI_HI, 4'hF, 32'h8000_0001);
      wr(EEI_LO, 4'hF, 32'h0);
      wr(CMD_A, 4'b0100, 32'd40 << 16);
      wr(CMD_A, 4'b1000, 32'd63 << 24);
      wr(CMD_A, 4'b1100, 32'h0C0C_0000);
      eei_m = 64'h0000_0101_0000_0000;
      rd64(EEI_HI, v64); check("R4 eei set/clear", v64, eei_m);

      // R12 out-of-range indices ignored
      for (int v = NCH; v < 256; v++) begin
         wr(CMD_A, 4'hF, {4{8'(v)}});
         check("R12 req unchanged", 64'(req_enable), req_m);
         wr(CMD_B, 4'hF, {4{8'(v)}});
         check("R12 no start", 64'(start_pulse), 0);
      end
      rd64(EEI_HI, v64); check("R12 eei unchanged", v64, eei_m);
      rd64(INT_HI, v64); check("R12 int unchanged", v64, 0);
      rd64(REQ_HI, v64); check("R12 req read", v64, req_m);

      wr(EEI_HI, 4'hF, 0); wr(EEI_LO, 4'hF, 0);

      // R6 / R13 done event per channel
      for (int c = 0; c < NCH; c++) begin
         pulse_done(64'd1 << c);
         rd64(INT_HI, v64); check("R6 int flag", v64, 64'd1 << c);
         check("R6 done bit", 64'(chan_done), 64'd1 << c);
         check("R13 irq on int", irq, 1);
         wr(CMD_B, 4'b0001, 32'(c));
         rd64(INT_HI, v64); check("R7 clear-int cmd", v64, 0);
         check("R13 irq low", irq, 0);
         wr(CMD_B, 4'b1000, 32'(c) << 24);
         check("R6 clear done", 64'(chan_done), 0);
      end

      // R7 write-ones clear and same-cycle events
      pulse_done('1);
      wr(INT_HI, 4'hF, 32'hFFFF_0000);
      rd64(INT_HI, v64); check("R7 w1c high", v64, 64'h0000_FFFF_FFFF_FFFF);
      wr(INT_LO, 4'hF, 32'hFFFF_FFFF);
      wr(INT_HI, 4'hF, 32'hFFFF_FFFF);
      rd64(INT_HI, v64); check("R7 w1c all", v64, 0);
      check("R13 irq clear", irq, 0);
      wr_full(CMD_B, 4'b0001, 32'd9, 64'd1 << 9, 1'b0, 6'd0, 10'd0);
      rd64(INT_HI, v64); check("R7 event beats clear cmd", v64, 64'd1 << 9);
      wr_full(INT_LO, 4'hF, 32'hFFFF_FFFF, 64'd1 << 10, 1'b0, 6'd0, 10'd0);
      rd64(INT_HI, v64); check("R7 event beats w1c", v64, 64'd1 << 10);
      wr(INT_LO, 4'hF, 32'hFFFF_FFFF);

      // R8 / R9 / R10 error path
      pulse_err(6'd17, 10'h3FF);
      rd64(ERR_HI, v64); check("R8 err flag", v64, 64'd1 << 17);
      check("R8 masked irq", irq, 0);
      rd(ESTAT, d); check("R9 capture", d, 32'h8000_D1FF);
      pulse_err(6'd3, 10'h001);
      rd64(ERR_HI, v64); check("R8 second flag", v64, (64'd1 << 17) | (64'd1 << 3));
      rd(ESTAT, d); check("R9 first kept", d, 32'h8000_D1FF);
      wr(CMD_A, 4'b0100, 32'd3 << 16);
      check("R8 enabled irq", irq, 1);
      wr(CMD_B, 4'b0010, 32'd3 << 8);
      rd64(ERR_HI, v64); check("R7 clear-err cmd", v64, 64'd1 << 17);
      rd(ESTAT, d); check("R10 status cleared", d, 0);
      check("R13 irq after clear", irq, 0);
      pulse_err(6'd3, 10'h001);
      rd(ESTAT, d); check("R9 recapture", d, 32'h8000_0301);
      check("R8 irq again", irq, 1);
      wr_full(CMD_B, 4'b0010, 32'd3 << 8, '0, 1'b1, 6'd20, 10'h200);
      rd(ESTAT, d); check("R10 same-cycle capture", d, 32'h8000_9400);
      rd64(ERR_HI, v64); check("R7 err flags", v64, (64'd1 << 17) | (64'd1 << 20));
      wr(ERR_HI, 4'hF, 32'hFFFF_FFFF);
      wr(ERR_LO, 4'hF, 32'hFFFF_FFFF);
      rd64(ERR_HI, v64); check("R7 err w1c", v64, 0);
      rd(ESTAT, d); check("R9 status untouched by w1c", d, 32'h8000_9400);

      // R11 start pulses
      for (int c = 0; c < NCH; c++) begin
         wr(CMD_B, 4'b0100, 32'(c) << 16);
         check("R11 start pulse", 64'(start_pulse), 64'd1 << c);
         @(negedge clk);
         check("R11 pulse ends", 64'(start_pulse), 0);
      end

      finished = 1;
      report;
      $finish;
   end
endmodule